// File: doc/BRIEF.md
# Multiplexed ADC Sequencer Front-End

This block sits between a host register port and an external analog-to-digital converter on an eight-channel acquisition card. The host fills a channel/gain queue, picks a conversion clock (an internal pacer tick, an external pacer edge, or single software-started conversions), and then drains tagged results from a sample FIFO. Each conversion issues a one-cycle start strobe, presents the channel and gain of the current queue entry to the analog front end, and stores the returned 12-bit result together with its channel number.

Paced acquisition can be held off until an external start edge arrives. That hold-off is ignored whenever the conversions are themselves clocked externally. The block tracks FIFO overrun, keeps a sticky pending-interrupt flag, drives an interrupt line gated by an enable bit, and flags a queue whose layout breaks the even/odd channel rules.

Top module: `acq_seq_frontend`

## Requirements
- R1: Writing an index to offset 6 and then a byte to offset 7 stores a queue entry at that index, with channel in byte bits [2:0] and gain code in bits [7:4]. During a conversion, conv_chan and conv_gain show the entry being converted.
- R2: Every FIFO word read from offset 0 carries the converter result in bits [15:4] and the channel number in bits [3:0], with bit 3 zero.
- R3: Any write to offset 0 starts exactly one conversion using queue entry 0, whatever the clock select.
- R4: In the control byte at offset 5, bits [1:0] = 3 converts on each pacer_tick pulse and bits [1:0] = 2 converts on each rising edge of ext_pacer. Codes 0 and 1 start no paced conversion, and each mode ignores the other mode's trigger input. The byte reads back at offset 5.
- R5: Paced conversions step through the queue from index 0 and wrap to index 0 after the highest index written since the clock select last went from a paced code to a non-paced code. That transition also returns the pointer to index 0.
- R6: Results leave the FIFO in conversion order. A conversion that completes while the FIFO holds FIFO_DEPTH words is discarded and sets status bit 5. Bit 5 stays set until any write to offset 4.
- R7: Status bit 7 (offset 2) is set while the FIFO holds data or an interrupt is pending. The pending flag sets while the FIFO is non-empty with control bit 7 set, and only a write to offset 4 clears it. irq is the pending flag ANDed with control bit 7.
- R8: Writing 1 to status bit 0 (read back at offset 2, bit 0) holds off paced conversions until a rising edge on ext_start. Writing the status register re-arms the hold-off. The hold-off has no effect while bits [1:0] = 2.
- R9: queue_err is high when any entry up to the highest written index has a gain code above 8. It is also high when more than one entry is in use and either the count is odd or an entry's channel parity differs from its index parity.
- R10: conv_start is a single-cycle pulse. A trigger that arrives while a conversion is outstanding is dropped.
- R11: irq_line equals control bits [6:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at offset 0) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| pacer_tick | input | 1 | Internal pacer pulse, synchronous |
| ext_pacer | input | 1 | External conversion clock, asynchronous |
| ext_start | input | 1 | External start gate, asynchronous |
| conv_start | output | 1 | Converter start strobe |
| conv_chan | output | 3 | Channel of the current conversion |
| conv_gain | output | 4 | Gain code of the current conversion |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 12 | Converter result, valid with conv_done |
| irq | output | 1 | Interrupt request |
| irq_line | output | 3 | Interrupt line select code |
| queue_err | output | 1 | Queue layout violates the channel rules |

## Verification
A pointer or wrap-limit error shows up as a wrong channel tag in the very next FIFO word read after the faulty conversion, so sequences of paced reads across several wraps expose it within one queue pass. A stuck busy flag stops all further data at the ports, and a missed busy check shows as two start pulses or an extra FIFO word within one converter latency. Overrun and pending-flag faults appear in status bits 5 and 7 on the first read after the FIFO fills or the clear write, and a wrong length tracker flips queue_err right after the offending queue write.

// File: rtl/acq_pkg.sv
package acq_pkg;
   localparam logic [2:0] OFF_DATA  = 3'd0;
   localparam logic [2:0] OFF_CS    = 3'd2;
   localparam logic [2:0] OFF_CLR   = 3'd4;
   localparam logic [2:0] OFF_ICTRL = 3'd5;
   localparam logic [2:0] OFF_QADDR = 3'd6;
   localparam logic [2:0] OFF_QDATA = 3'd7;

   localparam int GAIN_MAX = 8;

   typedef enum logic [1:0] {
      CK_OFF0 = 2'd0,
      CK_OFF1 = 2'd1,
      CK_EXT  = 2'd2,
      CK_INT  = 2'd3
   } clk_sel_e;

   typedef struct packed {
      logic [3:0] gain;
      logic [2:0] chan;
   } qent_t;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);
   logic [STAGES-1:0] sh;
   logic              last_q;

   if (STAGES < 1) begin : g_bad_stages
      $error("acq_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-2:0], d};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sh[STAGES-1];
   end

   assign rise = sh[STAGES-1] & ~last_q;
endmodule

// File: rtl/acq_trig.sv
module acq_trig import acq_pkg::*; #(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  clk_sel_e sel,
   input  logic     gate_en,
   input  logic     gate_clr,
   input  logic     pacer_tick,
   input  logic     ext_pacer,
   input  logic     ext_start,
   output logic     paced_trig
);
   logic pace_rise, start_rise, armed_q, gate_eff, tick;

   acq_sync #(.STAGES(SYNC_STAGES)) u_pace_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_pacer), .rise(pace_rise)
   );
   acq_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_start), .rise(start_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          armed_q <= 1'b0;
      else if (gate_clr)   armed_q <= 1'b0;
      else if (start_rise) armed_q <= 1'b1;
   end

   assign gate_eff   = gate_en && (sel != CK_EXT);
   assign tick       = ((sel == CK_INT) && pacer_tick) || ((sel == CK_EXT) && pace_rise);
   assign paced_trig = tick && (!gate_eff || armed_q);
endmodule

// File: rtl/acq_queue.sv
module acq_queue import acq_pkg::*; #(
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  qent_t            wentry,
   input  logic             clr_last,
   input  logic [IDX_W-1:0] ridx,
   output qent_t            rentry,
   output logic [IDX_W-1:0] last_idx,
   output logic             err
);
   qent_t            mem [DEPTH];
   logic [IDX_W-1:0] last_q;
   logic [DEPTH-1:0] in_len, par_bad, rng_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wentry;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     last_q <= '0;
      else if (clr_last)              last_q <= we ? widx : '0;
      else if (we && (widx > last_q)) last_q <= widx;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_rule
      assign in_len[i]  = (IDX_W'(i) <= last_q);
      assign par_bad[i] = (mem[i].chan[0] != 1'(i % 2));
      assign rng_bad[i] = (mem[i].gain > 4'(GAIN_MAX));
   end

   assign rentry   = mem[ridx];
   assign last_idx = last_q;
   assign err      = (|(rng_bad & in_len)) ||
                     ((last_q != '0) && (!last_q[0] || (|(par_bad & in_len))));
endmodule

// File: rtl/acq_fifo.sv
module acq_fifo #(
   parameter int DEPTH = 1024,
   parameter int WIDTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [AW:0]      cnt_q;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rdata = mem[rp_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == (AW+1)'(DEPTH));
endmodule

// File: rtl/acq_seq_frontend.sv
module acq_seq_frontend import acq_pkg::*; #(
   parameter int QUEUE_DEPTH = 256,
   parameter int FIFO_DEPTH  = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [15:0] reg_rdata,
   input  logic        pacer_tick,
   input  logic        ext_pacer,
   input  logic        ext_start,
   output logic        conv_start,
   output logic [2:0]  conv_chan,
   output logic [3:0]  conv_gain,
   input  logic        conv_done,
   input  logic [11:0] conv_result,
   output logic        irq,
   output logic [2:0]  irq_line,
   output logic        queue_err
);
   localparam int IDX_W  = $clog2(QUEUE_DEPTH);
   localparam int WORD_W = 16;

   if (QUEUE_DEPTH < 2 || QUEUE_DEPTH > 256 || (QUEUE_DEPTH & (QUEUE_DEPTH - 1)) != 0) begin : g_bad_qd
      $error("acq_seq_frontend: QUEUE_DEPTH must be a power of two in 2..256");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_fd
      $error("acq_seq_frontend: FIFO_DEPTH must be a power of two, at least 2");
   end

   logic [7:0]       ictrl_q;
   logic             gate_en_q, ovr_q, pend_q, busy_q, start_q;
   logic [IDX_W-1:0] qaddr_q, ptr_q, last_idx, rd_idx;
   qent_t            cur_q, rd_ent;
   clk_sel_e         sel;
   logic             paced, new_paced, clr_last, paced_trig;
   logic             wr_data, wr_cs, wr_clr, wr_ictrl, wr_qaddr, wr_qdata;
   logic             start_go, fifo_push, fifo_pop, fifo_empty, fifo_full;
   logic [WORD_W-1:0] fifo_wdata, fifo_head;
   logic [7:0]       status;
   logic             unused_bits;

   assign wr_data  = reg_wr && (reg_addr == OFF_DATA);
   assign wr_cs    = reg_wr && (reg_addr == OFF_CS);
   assign wr_clr   = reg_wr && (reg_addr == OFF_CLR);
   assign wr_ictrl = reg_wr && (reg_addr == OFF_ICTRL);
   assign wr_qaddr = reg_wr && (reg_addr == OFF_QADDR);
   assign wr_qdata = reg_wr && (reg_addr == OFF_QDATA);
   assign unused_bits = reg_wdata[3];

   assign sel       = clk_sel_e'(ictrl_q[1:0]);
   assign paced     = (sel == CK_EXT) || (sel == CK_INT);
   assign new_paced = (reg_wdata[1:0] == CK_EXT) || (reg_wdata[1:0] == CK_INT);
   assign clr_last  = wr_ictrl && paced && !new_paced;

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ictrl_q   <= '0;
         gate_en_q <= 1'b0;
         qaddr_q   <= '0;
      end else begin
         if (wr_ictrl) ictrl_q   <= reg_wdata;
         if (wr_cs)    gate_en_q <= reg_wdata[0];
         if (wr_qaddr) qaddr_q   <= reg_wdata[IDX_W-1:0];
      end
   end

   acq_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .we(wr_qdata), .widx(qaddr_q),
      .wentry('{gain: reg_wdata[7:4], chan: reg_wdata[2:0]}),
      .clr_last(clr_last),
      .ridx(rd_idx), .rentry(rd_ent),
      .last_idx(last_idx), .err(queue_err)
   );

   acq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk(clk), .rst_n(rst_n), .sel(sel),
      .gate_en(gate_en_q), .gate_clr(wr_cs),
      .pacer_tick(pacer_tick), .ext_pacer(ext_pacer), .ext_start(ext_start),
      .paced_trig(paced_trig)
   );

   // conversion control
   assign start_go = !busy_q && (wr_data || paced_trig);
   assign rd_idx   = wr_data ? '0 : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         cur_q   <= '0;
         ptr_q   <= '0;
      end else begin
         start_q <= start_go;
         if (start_go) begin
            busy_q <= 1'b1;
            cur_q  <= rd_ent;
         end else if (busy_q && conv_done) begin
            busy_q <= 1'b0;
         end
         if (!paced)
            ptr_q <= '0;
         else if (start_go && !wr_data)
            ptr_q <= (ptr_q >= last_idx) ? '0 : ptr_q + 1'b1;
      end
   end

   assign conv_start = start_q;
   assign conv_chan  = cur_q.chan;
   assign conv_gain  = cur_q.gain;

   // sample storage
   assign fifo_push  = busy_q && conv_done && !fifo_full;
   assign fifo_wdata = {conv_result, 1'b0, cur_q.chan};
   assign fifo_pop   = reg_rd && (reg_addr == OFF_DATA);

   acq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(fifo_push), .wdata(fifo_wdata),
      .pop(fifo_pop), .rdata(fifo_head),
      .empty(fifo_empty), .full(fifo_full)
   );

   // flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         ovr_q  <= (ovr_q && !wr_clr) || (busy_q && conv_done && fifo_full);
         pend_q <= (pend_q && !wr_clr) || (!fifo_empty && ictrl_q[7]);
      end
   end

   assign irq      = pend_q && ictrl_q[7];
   assign irq_line = ictrl_q[6:4];
   assign status   = {pend_q || !fifo_empty, 1'b0, ovr_q, 4'b0000, gate_en_q};

   always_comb begin
      case (reg_addr)
         OFF_DATA:  reg_rdata = fifo_head;
         OFF_CS:    reg_rdata = {8'h00, status};
         OFF_ICTRL: reg_rdata = {8'h00, ictrl_q};
         OFF_QADDR: reg_rdata = {{(WORD_W-IDX_W){1'b0}}, qaddr_q};
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic conv_start,
   input logic conv_done,
   input logic busy,
   input logic irq,
   input logic ie,
   input logic fifo_empty,
   input logic fifo_full,
   input logic pend,
   input logic ovr,
   input logic clr_wr
);
   assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !conv_start);

   assert_irq_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ie);

   assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ie && !fifo_empty) |=> pend);

   assert_ovr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(conv_done && fifo_full));

   assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !(conv_done && fifo_full)) |=> !ovr);
endmodule

bind acq_seq_frontend acq_seq_chk u_acq_seq_chk (
   .clk(clk), .rst_n(rst_n),
   .conv_start(conv_start), .conv_done(conv_done),
   .busy(busy_q), .irq(irq), .ie(ictrl_q[7]),
   .fifo_empty(fifo_empty), .fifo_full(fifo_full),
   .pend(pend_q), .ovr(ovr_q), .clr_wr(wr_clr)
);

// File: tb/test_acq_seq_frontend.sv
`timescale 1ns/1ps
module test_acq_seq_frontend;
   localparam int QD = 16;
   localparam int FD = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, reg_wr, reg_rd, pacer_tick, ext_pacer, ext_start, conv_done;
   logic [2:0]  reg_addr;
   logic [7:0]  reg_wdata;
   logic [15:0] reg_rdata;
   logic        conv_start, irq, queue_err;
   logic [2:0]  conv_chan, irq_line;
   logic [3:0]  conv_gain;
   logic [11:0] conv_result;

   acq_seq_frontend #(.QUEUE_DEPTH(QD), .FIFO_DEPTH(FD)) i_acq_seq_frontend (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pacer_tick(pacer_tick), .ext_pacer(ext_pacer), .ext_start(ext_start),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_gain(conv_gain),
      .conv_done(conv_done), .conv_result(conv_result),
      .irq(irq), .irq_line(irq_line), .queue_err(queue_err)
   );

   int total = 0, bad = 0, starts = 0;
   int m_cnt = 0;
   logic [3:0] m_seq = '0, e_seq = '0;
   logic [2:0] m_chan;
   logic [3:0] m_gain;
   logic [2:0] qc [QD];
   logic [3:0] qg [QD];
   logic [15:0] v;

   // converter model: result = {gain, 0, chan, seq}, three cycles after the strobe
   always @(negedge clk) begin
      conv_done = 1'b0;
      if (m_cnt > 0) begin
         m_cnt--;
         if (m_cnt == 0) begin
            conv_done   = 1'b1;
            conv_result = {m_gain, 1'b0, m_chan, m_seq};
            m_seq++;
         end
      end
      if (rst_n && conv_start) begin
         starts++;
         m_cnt  = 3;
         m_chan = conv_chan;
         m_gain = conv_gain;
      end
   end

   function automatic logic [15:0] exp_word(input logic [2:0] c, input logic [3:0] g, input logic [3:0] s);
      return {g, 1'b0, c, s, 1'b0, c};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = (a == 3'd0);
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic qset(input int idx, input logic [2:0] c, input logic [3:0] g);
      wr(3'd6, 8'(idx));
      wr(3'd7, {g, 1'b0, c});
      qc[idx] = c; qg[idx] = g;
   endtask

   task automatic qprog4();
      qset(0, 3'd0, 4'd1);
      qset(1, 3'd3, 4'd2);
      qset(2, 3'd6, 4'd0);
      qset(3, 3'd5, 4'd8);
   endtask

   task automatic tick();
      @(negedge clk); pacer_tick = 1'b1;
      @(negedge clk); pacer_tick = 1'b0;
      idle(10);
   endtask

   task automatic pace_edge();
      @(negedge clk); ext_pacer = 1'b1; idle(3);
      ext_pacer = 1'b0; idle(10);
   endtask

   task automatic expect_idx(input string tag, input int idx);
      rd(3'd0, v);
      chk(tag, v, exp_word(qc[idx], qg[idx], e_seq));
      e_seq++;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      pacer_tick = 1'b0; ext_pacer = 1'b0; ext_start = 1'b0;
      conv_done = 1'b0; conv_result = '0;
      for (int i = 0; i < QD; i++) begin qc[i] = '0; qg[i] = '0; end
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // reset state
      rd(3'd2, v);  chk("reset status R7", v, 0);
      rd(3'd5, v);  chk("reset ctrl R4", v, 0);
      chk("reset irq R7", irq, 0);
      chk("reset queue_err R9", queue_err, 0);
      chk("reset irq_line R11", irq_line, 0);

      // R1 R2 R3: software conversions over every channel and legal gain
      for (int g = 0; g <= 8; g++) begin
         for (int c = 0; c < 8; c++) begin
            qset(0, 3'(c), 4'(g));
            wr(3'd0, 8'h00);
            idle(10);
            rd(3'd2, v); chk("sw ready R3", v[7], 1);
            expect_idx("sw word R1 R2 R3", 0);
         end
      end
      rd(3'd2, v); chk("sweep drained R2", v[7], 0);

      // R10: second trigger during a busy conversion is dropped
      begin
         int s0;
         s0 = starts;
         @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = '0;
         @(negedge clk);
         @(negedge clk); reg_wr = 1'b0;
         idle(12);
         chk("one start R10", starts - s0, 1);
         expect_idx("busy word R10", 0);
         rd(3'd2, v); chk("no extra word R10", v[7], 0);
      end

      // R5: paced stepping with wrap at highest written index
      qprog4();
      chk("clean queue R9", queue_err, 0);
      wr(3'd5, 8'h03);
      for (int k = 0; k < 10; k++) tick();
      for (int k = 0; k < 10; k++) expect_idx("int pacer order R5", k % 4);
      wr(3'd5, 8'h00);
      wr(3'd5, 8'h03);
      tick(); tick();
      expect_idx("wrap limit reset R5", 0);
      expect_idx("wrap limit reset R5", 0);

      // R4: non-paced codes and cross-mode inputs start nothing
      wr(3'd5, 8'h00);
      tick(); pace_edge();
      wr(3'd5, 8'h01);
      tick(); pace_edge();
      rd(3'd2, v); chk("off codes R4", v[7], 0);
      rd(3'd5, v); chk("ctrl readback R4", v, 8'h01);
      qprog4();
      wr(3'd5, 8'h02);
      tick();
      rd(3'd2, v); chk("ext mode ignores tick R4", v[7], 0);
      for (int k = 0; k < 6; k++) pace_edge();
      for (int k = 0; k < 6; k++) expect_idx("ext pacer order R4 R5", k % 4);

      // R8: external start gate
      wr(3'd5, 8'h00);
      qprog4();
      wr(3'd2, 8'h01);
      wr(3'd5, 8'h03);
      tick();
      rd(3'd2, v); chk("gated hold-off R8", v, 8'h01);
      @(negedge clk); ext_start = 1'b1; idle(3); ext_start = 1'b0; idle(4);
      tick();
      expect_idx("gate opened R8", 0);
      tick();
      expect_idx("gate stays open R8", 1);
      wr(3'd5, 8'h00);
      qprog4();
      wr(3'd2, 8'h01);
      wr(3'd5, 8'h02);
      pace_edge();
      expect_idx("gate ignored ext clock R8", 0);
      wr(3'd2, 8'h00);
      wr(3'd5, 8'h00);

      // R9: queue rule flag
      qprog4();
      chk("even length ok R9", queue_err, 0);
      qset(3, 3'd4, 4'd0); chk("odd index even chan R9", queue_err, 1);
      qset(3, 3'd5, 4'd0); chk("parity fixed R9", queue_err, 0);
      qset(4, 3'd4, 4'd0); chk("odd length R9", queue_err, 1);
      qset(5, 3'd5, 4'd0); chk("length six ok R9", queue_err, 0);
      qset(2, 3'd6, 4'd9); chk("gain 9 illegal R9", queue_err, 1);
      qset(2, 3'd6, 4'd0); chk("gain fixed R9", queue_err, 0);
      wr(3'd5, 8'h03);
      wr(3'd5, 8'h00);
      qset(0, 3'd1, 4'd0); chk("single entry any parity R9", queue_err, 0);
      qset(0, 3'd1, 4'd12); chk("single entry gain 12 R9", queue_err, 1);
      qset(0, 3'd0, 4'd1);

      // R6: overrun
      for (int k = 0; k <= FD; k++) begin
         wr(3'd0, 8'h00);
         idle(10);
      end
      rd(3'd2, v);
      chk("overrun set R6", v[5], 1);
      chk("full ready R7", v[7], 1);
      for (int k = 0; k < FD; k++) expect_idx("fifo order R6", 0);
      e_seq++;
      rd(3'd2, v);
      chk("drained R6", v[7], 0);
      chk("overrun sticky R6", v[5], 1);
      wr(3'd4, 8'h00);
      rd(3'd2, v); chk("overrun cleared R6", v[5], 0);

      // R7: interrupt
      wr(3'd5, 8'h80);
      wr(3'd0, 8'h00); idle(10);
      chk("irq on data R7", irq, 1);
      wr(3'd4, 8'h00); idle(1);
      chk("irq stays with data R7", irq, 1);
      expect_idx("irq word R7", 0);
      idle(1);
      chk("pend sticky after drain R7", irq, 1);
      wr(3'd4, 8'h00); idle(1);
      chk("irq cleared R7", irq, 0);
      wr(3'd5, 8'h00);
      wr(3'd0, 8'h00); idle(10);
      chk("irq masked R7", irq, 0);
      rd(3'd2, v); chk("ready without irq R7", v[7], 1);
      expect_idx("masked word R7", 0);

      // R11: line select
      for (int s = 0; s < 8; s++) begin
         wr(3'd5, 8'(s << 4));
         chk("irq_line R11", irq_line, s);
         rd(3'd5, v); chk("line readback R11", v, s << 4);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule